// File: doc/BRIEF.md
# Safe Flash Page-Reclaim Sequencer

This block reclaims space in a flash array that is programmed one sector at a time and erased one page at a time. A request names a page and gives a keep mask with one bit per sector. Each kept sector is first copied into a nonvolatile staging store, and every copy is confirmed by the store's done handshake. Only after all of them are confirmed, and a staging-complete marker has been written to the nonvolatile side, does the block erase the page. It then programs the kept sectors back into their original slots and clears the marker.

Flash and staging memories sit outside the block. They are driven through one command port with a one-cycle start strobe and a done strobe. The marker, the page number and the keep mask are kept in the nonvolatile store and fed back to the block. After any reset, a set marker makes the block finish the interrupted reclaim on its own: it erases the page and restores the kept sectors, with no new staging pass.

Top module: `page_reclaim_seq`

## Requirements
- R1: A memory operation is a one-cycle `op_start_o` pulse with `op_code_o` = 1 (copy flash sector to staging slot of the same index), 2 (erase page) or 3 (program flash sector from staging slot). The next operation starts only after `op_done_i` has answered the previous one.
- R2: For a request with keep mask bit i set (bit i selects sector i), sector i is copied to staging exactly once. Copies are issued in ascending sector order.
- R3: The page erase starts only after every kept sector's copy has been confirmed and `mark_set_o` has pulsed. `mark_set_o` pulses once per staged request.
- R4: After the erase completes, each kept sector is programmed back exactly once in ascending order, and then `mark_clr_o` pulses. Kept sectors then hold their former contents and all other sectors of the page read erased.
- R5: A keep mask of all zeros issues no copy, no restore and no marker pulse. The page is erased and the request completes.
- R6: A keep mask of all ones produces a one-cycle `reject_o`, issues no memory operation, does not pulse `done_o`, and leaves the page unchanged.
- R7: `done_o` is high for exactly one cycle when a sequence completes.
- R8: A request that arrives while `busy_o` is high is ignored. It starts no operation and yields no extra `done_o`.
- R9: If `mark_i` is high when reset is released, the block erases page `mark_page_i`, restores the sectors selected by `mark_keep_i`, clears the marker and pulses `done_o`, with no copy operations.
- R10: During reset `op_start_o`, `done_o` and `reject_o` are low. With `mark_i` low, `busy_o` is low one cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Request strobe, taken when idle |
| req_page_i | input | PAGE_W | Page to reclaim |
| req_keep_i | input | SECTORS | Keep mask, bit i = sector i |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle completion pulse |
| reject_o | output | 1 | One-cycle rejection pulse |
| op_start_o | output | 1 | Memory operation start strobe |
| op_code_o | output | 2 | 1 copy, 2 erase, 3 program back |
| op_page_o | output | PAGE_W | Page of the operation |
| op_sector_o | output | log2(SECTORS) | Sector of the operation |
| op_done_i | input | 1 | Memory operation finished |
| keep_o | output | SECTORS | Active keep mask, saved with the marker |
| mark_set_o | output | 1 | Write staging-complete marker |
| mark_clr_o | output | 1 | Clear staging-complete marker |
| mark_i | input | 1 | Stored marker value |
| mark_page_i | input | PAGE_W | Stored page number |
| mark_keep_i | input | SECTORS | Stored keep mask |

## Verification
Two events can meet in the same clock edge: a new request and the end of the running sequence's memory operation. A new request can also meet the boot check of the stored marker. The bench pulses a request for another page while a reclaim is still waiting for `op_done_i`. It then judges, at the flash model, that the second page is untouched and that exactly one erase and one `done_o` occurred. For the resume path it preloads the marker and staging contents, pulses reset, and compares the restored page against the staged data while counting that no copy was issued.

// File: rtl/pgr_pkg.sv
package pgr_pkg;

  typedef enum logic [3:0] {
    S_BOOT, S_IDLE, S_REJ,
    S_STG_GO, S_STG_W, S_MARK,
    S_ERS_GO, S_ERS_W,
    S_RST_GO, S_RST_W, S_UNMARK, S_FIN
  } seq_state_t;

  localparam logic [1:0] OP_NONE    = 2'd0;
  localparam logic [1:0] OP_STAGE   = 2'd1;
  localparam logic [1:0] OP_ERASE   = 2'd2;
  localparam logic [1:0] OP_RESTORE = 2'd3;

endpackage

// File: rtl/sector_pick.sv
module sector_pick #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0] mask,
  input  logic [IW:0]  from,
  output logic         hit,
  output logic [IW-1:0] idx
);
  // lowest set bit at or above 'from'
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i] && (32'(i) >= 32'(from))) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/mask_class.sv
module mask_class #(
  parameter int N = 16
) (
  input  logic [N-1:0] mask,
  output logic         none,
  output logic         all
);
  assign none = ~|mask;
  assign all  = &mask;
endmodule

// File: rtl/page_reclaim_seq.sv
module page_reclaim_seq
  import pgr_pkg::*;
#(
  parameter int SECTORS = 16,
  parameter int PAGE_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_i,
  input  logic [PAGE_W-1:0]          req_page_i,
  input  logic [SECTORS-1:0]         req_keep_i,
  output logic                       busy_o,
  output logic                       done_o,
  output logic                       reject_o,
  output logic                       op_start_o,
  output logic [1:0]                 op_code_o,
  output logic [PAGE_W-1:0]          op_page_o,
  output logic [$clog2(SECTORS)-1:0] op_sector_o,
  input  logic                       op_done_i,
  output logic [SECTORS-1:0]         keep_o,
  output logic                       mark_set_o,
  output logic                       mark_clr_o,
  input  logic                       mark_i,
  input  logic [PAGE_W-1:0]          mark_page_i,
  input  logic [SECTORS-1:0]         mark_keep_i
);
  localparam int IW = $clog2(SECTORS);

  seq_state_t         state, nstate;
  logic [PAGE_W-1:0]  page_q;
  logic [SECTORS-1:0] keep_q;
  logic [IW-1:0]      sec_q;

  // scan for next kept sector
  logic [SECTORS-1:0] pk_mask;
  logic [IW:0]        pk_from;
  logic               pk_hit;
  logic [IW-1:0]      pk_idx;

  assign pk_mask = (state == S_IDLE) ? req_keep_i : keep_q;
  assign pk_from = (state == S_STG_W || state == S_RST_W) ? ({1'b0, sec_q} + 1'b1) : '0;

  sector_pick #(.N(SECTORS), .IW(IW)) u_pick (
    .mask(pk_mask), .from(pk_from), .hit(pk_hit), .idx(pk_idx)
  );

  logic req_none, req_all, keep_none, keep_all_unused;
  mask_class #(.N(SECTORS)) u_req_cls (.mask(req_keep_i), .none(req_none), .all(req_all));
  mask_class #(.N(SECTORS)) u_keep_cls (.mask(keep_q), .none(keep_none), .all(keep_all_unused));

  // named events
  logic stage_go, erase_go, restore_go, accept;
  assign stage_go   = (state == S_STG_GO);
  assign erase_go   = (state == S_ERS_GO);
  assign restore_go = (state == S_RST_GO);
  assign accept     = (state == S_IDLE) && req_i;

  always_comb begin
    nstate = state;
    unique case (state)
      S_BOOT:   nstate = mark_i ? S_ERS_GO : S_IDLE;
      S_IDLE:   if (req_i) nstate = req_all ? S_REJ : (req_none ? S_ERS_GO : S_STG_GO);
      S_REJ:    nstate = S_IDLE;
      S_STG_GO: nstate = S_STG_W;
      S_STG_W:  if (op_done_i) nstate = pk_hit ? S_STG_GO : S_MARK;
      S_MARK:   nstate = S_ERS_GO;
      S_ERS_GO: nstate = S_ERS_W;
      S_ERS_W:  if (op_done_i) nstate = pk_hit ? S_RST_GO : S_FIN;
      S_RST_GO: nstate = S_RST_W;
      S_RST_W:  if (op_done_i) nstate = pk_hit ? S_RST_GO : S_UNMARK;
      S_UNMARK: nstate = S_FIN;
      S_FIN:    nstate = S_IDLE;
      default:  nstate = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_BOOT;
      page_q <= '0;
      keep_q <= '0;
      sec_q  <= '0;
    end else begin
      state <= nstate;
      if (state == S_BOOT && mark_i) begin
        page_q <= mark_page_i;
        keep_q <= mark_keep_i;
      end
      if (accept && !req_all) begin
        page_q <= req_page_i;
        keep_q <= req_keep_i;
        sec_q  <= pk_idx;
      end
      if ((state == S_STG_W || state == S_ERS_W || state == S_RST_W) && op_done_i && pk_hit)
        sec_q <= pk_idx;
    end
  end

  assign busy_o      = (state != S_IDLE);
  assign done_o      = (state == S_FIN);
  assign reject_o    = (state == S_REJ);
  assign mark_set_o  = (state == S_MARK);
  assign mark_clr_o  = (state == S_UNMARK);
  assign op_start_o  = stage_go || erase_go || restore_go;
  assign op_code_o   = stage_go ? OP_STAGE : erase_go ? OP_ERASE : restore_go ? OP_RESTORE : OP_NONE;
  assign op_page_o   = page_q;
  assign op_sector_o = sec_q;
  assign keep_o      = keep_q;

  // erase only with marker stored or nothing to keep
  assert_erase_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> (mark_i || keep_none));

  // copy and program-back touch only kept sectors
  assert_kept_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_go || restore_go) |-> keep_q[sec_q]);

  assert_start_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_start_o |=> !op_start_o);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_reject_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reject_o |-> (!op_start_o && !done_o) ##1 !busy_o);

  assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && state != S_BOOT && !done_o && !reject_o) |=> ($stable(page_q) && $stable(keep_q)));

endmodule

// File: tb/page_reclaim_seq_tb.sv
`timescale 1ns/100ps
module page_reclaim_seq_tb;
  localparam int SECT = 16;
  localparam int PW   = 8;

  logic clk = 0, rst_n = 0;
  logic req = 0;
  logic [PW-1:0] req_page = 0;
  logic [SECT-1:0] req_keep = 0;
  logic busy, done, rej, op_start, op_done, mset, mclr;
  logic [1:0] op_code;
  logic [PW-1:0] op_page;
  logic [3:0] op_sec;
  logic [SECT-1:0] keep;

  // nonvolatile side and flash model
  logic nv_mark = 0;
  logic [PW-1:0] nv_page = 0;
  logic [SECT-1:0] nv_mask = 0;
  logic [31:0] fl [4][SECT];
  logic [31:0] stg [SECT];

  always #2.5 clk = ~clk;

  page_reclaim_seq #(.SECTORS(SECT), .PAGE_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_page_i(req_page), .req_keep_i(req_keep),
    .busy_o(busy), .done_o(done), .reject_o(rej), .op_start_o(op_start), .op_code_o(op_code),
    .op_page_o(op_page), .op_sector_o(op_sec), .op_done_i(op_done), .keep_o(keep),
    .mark_set_o(mset), .mark_clr_o(mclr), .mark_i(nv_mark), .mark_page_i(nv_page),
    .mark_keep_i(nv_mask)
  );

  // model controls
  logic log_clr = 0, fill_en = 0, pre_en = 0;
  logic [1:0] fill_pg = 0;
  logic [15:0] fill_tag = 0;
  logic [PW-1:0] pre_page = 0;
  logic [SECT-1:0] pre_mask = 0;

  int n_stg, n_ers, n_rst, n_mset, n_done, lat, last_s, last_r;
  logic bad_order, bad_guard;
  logic [1:0] m_code;
  logic [1:0] m_pg;
  logic [3:0] m_sec;

  always @(posedge clk) begin
    op_done <= 1'b0;
    if (log_clr) begin
      n_stg <= 0; n_ers <= 0; n_rst <= 0; n_mset <= 0; n_done <= 0;
      bad_order <= 0; bad_guard <= 0; last_s <= -1; last_r <= -1;
    end
    if (fill_en) for (int s = 0; s < SECT; s++) fl[fill_pg][s] <= {fill_tag, 16'(s)};
    if (pre_en) begin
      nv_mark <= 1'b1; nv_page <= pre_page; nv_mask <= pre_mask;
      for (int s = 0; s < SECT; s++) stg[s] <= 32'hC0DE0000 | s;
    end
    if (done) n_done <= n_done + 1;
    if (mset) begin nv_mark <= 1'b1; nv_page <= op_page; nv_mask <= keep; n_mset <= n_mset + 1; end
    if (mclr) nv_mark <= 1'b0;
    if (lat > 0) begin
      lat <= lat - 1;
      if (lat == 1) begin
        op_done <= 1'b1;
        case (m_code)
          2'd1: stg[m_sec] <= fl[m_pg][m_sec];
          2'd2: for (int s = 0; s < SECT; s++) fl[m_pg][s] <= 32'hFFFFFFFF;
          2'd3: fl[m_pg][m_sec] <= stg[m_sec];
          default: ;
        endcase
      end
    end else if (op_start) begin
      lat <= 3; m_code <= op_code; m_pg <= op_page[1:0]; m_sec <= op_sec;
      case (op_code)
        2'd1: begin n_stg <= n_stg + 1; if (int'(op_sec) <= last_s) bad_order <= 1; last_s <= int'(op_sec); end
        2'd2: begin
          n_ers <= n_ers + 1;
          if (!(nv_mark || keep == 0)) bad_guard <= 1;
          for (int s = 0; s < SECT; s++)
            if (keep[s] && stg[s] != fl[op_page[1:0]][s]) bad_guard <= 1;
        end
        2'd3: begin n_rst <= n_rst + 1; if (int'(op_sec) <= last_r) bad_order <= 1; last_r <= int'(op_sec); end
        default: ;
      endcase
    end
  end

  int checks = 0, fails = 0;

  task automatic check(input logic ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic pulse_ctl(input int which);
    @(negedge clk);
    if (which == 0) log_clr = 1; else if (which == 1) fill_en = 1; else pre_en = 1;
    @(negedge clk);
    log_clr = 0; fill_en = 0; pre_en = 0;
  endtask

  task automatic fill(input int p, input logic [15:0] tag);
    fill_pg = 2'(p); fill_tag = tag; pulse_ctl(1);
  endtask

  // wait for done or reject; returns which
  task automatic wait_end(output logic got_done, output logic got_rej);
    got_done = 0; got_rej = 0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (done) begin got_done = 1; break; end
      if (rej)  begin got_rej = 1;  break; end
    end
    if (!got_done && !got_rej) check(1'b0, "R7 timeout", 0, 1);
  endtask

  task automatic page_check(input int p, input logic [SECT-1:0] kept, input logic [15:0] tag,
                            input logic all_orig, input string rq);
    for (int s = 0; s < SECT; s++) begin
      logic [31:0] e;
      e = (all_orig || kept[s]) ? {tag, 16'(s)} : 32'hFFFFFFFF;
      check(fl[p][s] == e, rq, fl[p][s], e);
    end
  endtask

  localparam int NV = 6;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 16'h0001}, {2'd1, 16'h8000}, {2'd2, 16'hA5A5},
    {2'd3, 16'h0000}, {2'd0, 16'h7FFE}, {2'd1, 16'hFFFF}
  };

  initial begin
    logic gd, gr;
    // R10 reset state
    repeat (3) @(negedge clk);
    check(!op_start && !done && !rej, "R10 reset outputs", {op_start, done, rej}, 0);
    rst_n = 1;
    @(negedge clk); @(negedge clk);
    check(!busy, "R10 idle after reset", busy, 0);

    for (int v = 0; v < NV; v++) begin
      int p, cnt;
      logic [SECT-1:0] km;
      logic rj;
      logic [15:0] tag;
      p = int'(VEC[v][17:16]); km = VEC[v][15:0]; tag = 16'hA000 + 16'(v);
      rj = &km; cnt = $countones(km);
      fill(p, tag);
      pulse_ctl(0);
      @(negedge clk); req = 1; req_page = PW'(p); req_keep = km;
      @(negedge clk); req = 0;
      // a reject shows in this cycle already
      gr = rej; gd = 0;
      if (!gr) wait_end(gd, gr);
      if (gd) begin @(negedge clk); check(!done, "R7 done width", done, 0); end
      repeat (4) @(negedge clk);
      check(gr == rj, "R6 reject seen", gr, rj);
      check(gd == !rj, "R7 done seen", gd, !rj);
      check(n_stg == (rj ? 0 : cnt), "R2 copy count", n_stg, rj ? 0 : cnt);
      check(n_rst == (rj ? 0 : cnt), "R4 restore count", n_rst, rj ? 0 : cnt);
      check(n_ers == (rj ? 0 : 1), rj ? "R6 no erase" : "R5 erase count", n_ers, rj ? 0 : 1);
      check(n_mset == ((rj || km == 0) ? 0 : 1), "R3 R5 marker set count", n_mset, (rj || km == 0) ? 0 : 1);
      check(!bad_order, "R2 R4 ascending order", bad_order, 0);
      check(!bad_guard, "R3 erase after staging", bad_guard, 0);
      check(!nv_mark, "R4 marker cleared", nv_mark, 0);
      page_check(p, km, tag, rj, rj ? "R6 page untouched" : "R4 page contents");
    end

    // R8 request while busy
    fill(1, 16'hB100); fill(2, 16'hB200);
    pulse_ctl(0);
    @(negedge clk); req = 1; req_page = 8'd1; req_keep = 16'h00F0;
    @(negedge clk); req = 0;
    repeat (5) @(negedge clk);
    req = 1; req_page = 8'd2; req_keep = 16'h0000;
    @(negedge clk); req = 0;
    wait_end(gd, gr);
    repeat (40) @(negedge clk);
    check(n_done == 1, "R8 single done", n_done, 1);
    check(n_ers == 1, "R8 single erase", n_ers, 1);
    page_check(2, 16'h0, 16'hB200, 1'b1, "R8 other page untouched");
    page_check(1, 16'h00F0, 16'hB100, 1'b0, "R8 first page");

    // R9 resume after reset with marker set
    fill(3, 16'hDEAD);
    pulse_ctl(0);
    pre_page = 8'd3; pre_mask = 16'h0102; pulse_ctl(2);
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!op_start && !done, "R10 reset outputs", {op_start, done}, 0);
    rst_n = 1;
    wait_end(gd, gr);
    repeat (4) @(negedge clk);
    check(gd, "R9 resume done", gd, 1);
    check(n_stg == 0, "R9 no copies", n_stg, 0);
    check(n_rst == 2, "R9 restores", n_rst, 2);
    check(!nv_mark, "R9 marker cleared", nv_mark, 0);
    for (int s = 0; s < SECT; s++) begin
      logic [31:0] e;
      e = (s == 1 || s == 8) ? (32'hC0DE0000 | s) : 32'hFFFFFFFF;
      check(fl[3][s] == e, "R9 resumed page", fl[3][s], e);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    checks++; fails++;
    $display("FAIL watchdog act=%0d exp=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule